// File: doc/BRIEF.md
# Serial-Loaded Two-Stage Latch Control Register

This block turns a single serial data line into a wide bank of held control lines. Bits are fed in one per pulse of a shift load input. They travel along a chain of storage positions, and a second load input copies the whole chain at once into a hold register. The hold register drives the output bus directly. It can also drive a 2-to-4 one-hot decoder on a pair of its bits, chosen by a parameter.

Every storage element is a static, level-sensitive latch. Each latch has a true enable and a complemented enable. There is no clock: the two load inputs alone order every movement of data. Each chain position is a pair of latches on opposite phases of the shift load, so one shift pulse moves every bit by exactly one position. The hold register ignores the chain while shifting is in progress, so the output lines never show partial patterns. An active-low reset clears every latch.

Top module: `latch_ctl_reg`

## Requirements
- R1: While `rst_n` is low, every chain and hold latch clears to 0. Then `state_q` is all zeros, `ld_clash` is 0, and `dec_out` is 4'b0001 when the decoder is enabled and 4'b0000 when it is not.
- R2: Each falling edge of `shift_ld` moves chain position i into position i+1 and drops the old top position. Position 0 takes the value `ser_din` has at that falling edge.
- R3: After N shift pulses that present a word most significant bit first, a transfer makes `state_q` equal to that word, with word bit i on `state_q[i]`.
- R4: `state_q` does not change while `xfer_ld` is low, however many shift pulses occur.
- R5: While `xfer_ld` is high and `shift_ld` is low, `state_q` follows the chain. After `xfer_ld` falls, `state_q` holds its value for as long as the loads stay low, whatever `ser_din` does.
- R6: When `shift_ld` and `xfer_ld` are high together, `ld_clash` is 1 and the transfer is ignored, so `state_q` does not change. Otherwise `ld_clash` is 0.
- R7: With the decoder enabled, `dec_out[k]` is 1 exactly when {`state_q[DEC_LSB+1]`, `state_q[DEC_LSB]`} equals k, and the other three outputs are 0. With the decoder disabled, `dec_out` is 4'b0000.
- R8: A latch changes value only while its true enable is high and its complemented enable is low. In the chain, only the last value of `ser_din` before the falling edge of `shift_ld` is kept, even if `ser_din` toggles while `shift_ld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous clear of all latches |
| ser_din | input | 1 | Serial control data, 1 = high level |
| shift_ld | input | 1 | Shift load; each high-then-low pulse moves the chain by one |
| xfer_ld | input | 1 | Transfer load; copies the chain into the hold register |
| state_q | output | N | Held control outputs |
| dec_out | output | 4 | One-hot decode of two hold bits (zero when disabled) |
| ld_clash | output | 1 | High while both loads are asserted |

## Verification
The bench builds two copies of the block. The first has a 12-bit chain with the decoder on bits 6:5. Random words pushed through it place every bit at a distinct distance from the input, and words built for the purpose walk the decoder through all four codes. The second has a 2-bit chain with the decoder disabled. It shows the shortest chain dropping its top bit on the third shift, and it shows the decoder held at zero. Both copies share the same serial and load stimulus, so the clash and hold cases are checked at both widths.

// File: rtl/latch_ctl_pkg.sv
package latch_ctl_pkg;
   localparam int DEC_W = 4;
   typedef logic [DEC_W-1:0] dec_t;

   function automatic dec_t onehot_of(input logic [1:0] sel);
      dec_t r;
      r = '0;
      r[sel] = 1'b1;
      return r;
   endfunction
endpackage

// File: rtl/lvl_latch.sv
module lvl_latch #(
   parameter int W = 1
) (
   input  logic         rst_n,
   input  logic         ld,
   input  logic         ld_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("lvl_latch: W must be at least 1");
   end

   always_latch begin
      if (!rst_n)
         q <= '0;
      else if (ld && !ld_n)
         q <= d;
   end

   always @(q) begin
      if (rst_n) begin
         // R8
         latch_open_chk: assert (ld && !ld_n)
            else $error("latch output moved while closed");
      end
   end
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
   parameter int N = 8
) (
   input  logic         rst_n,
   input  logic         ser_din,
   input  logic         shift_ld,
   output logic [N-1:0] chain_q
);
   if (N < 2) begin : g_bad_n
      $error("shift_chain: N must be at least 2");
   end

   logic         sh_n;
   logic [N-1:0] mst_q;
   logic [N-1:0] mst_d;

   assign sh_n  = ~shift_ld;
   assign mst_d = {chain_q[N-2:0], ser_din};

   for (genvar i = 0; i < N; i++) begin : g_pos
      lvl_latch #(.W(1)) u_mst (
         .rst_n (rst_n),
         .ld    (shift_ld),
         .ld_n  (sh_n),
         .d     (mst_d[i]),
         .q     (mst_q[i])
      );
      lvl_latch #(.W(1)) u_slv (
         .rst_n (rst_n),
         .ld    (sh_n),
         .ld_n  (shift_ld),
         .d     (mst_q[i]),
         .q     (chain_q[i])
      );
   end

   logic armed;
   always_ff @(posedge shift_ld or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R2
   chain_step_chk: assert property (@(posedge shift_ld) disable iff (!rst_n)
      armed |-> (chain_q[N-1:1] == $past(chain_q[N-2:0])))
      else $error("chain did not advance by one position");
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
   parameter int N = 8
) (
   input  logic         rst_n,
   input  logic         xfer_ok,
   input  logic [N-1:0] chain_q,
   output logic [N-1:0] state_q
);
   logic xok_n;
   assign xok_n = ~xfer_ok;

   lvl_latch #(.W(N)) u_bank (
      .rst_n (rst_n),
      .ld    (xfer_ok),
      .ld_n  (xok_n),
      .d     (chain_q),
      .q     (state_q)
   );
endmodule

// File: rtl/dec_2to4.sv
module dec_2to4
   import latch_ctl_pkg::*;
#(
   parameter bit ENABLE = 1'b1
) (
   input  logic [1:0] sel,
   output dec_t       y
);
   if (ENABLE) begin : g_on
      assign y = onehot_of(sel);
      always_comb begin
         if (!$isunknown(sel)) begin
            // R7
            dec_onehot_chk: assert ($countones(y) == 1)
               else $error("decoder output not one-hot");
         end
      end
   end else begin : g_off
      assign y = '0;
   end
endmodule

// File: rtl/latch_ctl_reg.sv
module latch_ctl_reg
   import latch_ctl_pkg::*;
#(
   parameter int N       = 8,
   parameter bit DEC_EN  = 1'b1,
   parameter int DEC_LSB = 0
) (
   input  logic         rst_n,
   input  logic         ser_din,
   input  logic         shift_ld,
   input  logic         xfer_ld,
   output logic [N-1:0] state_q,
   output logic [DEC_W-1:0] dec_out,
   output logic         ld_clash
);
   localparam int DEC_MSB = DEC_LSB + 1;

   if (N < 2) begin : g_bad_n
      $error("latch_ctl_reg: N must be at least 2");
   end
   if (DEC_LSB < 0 || DEC_MSB >= N) begin : g_bad_sel
      $error("latch_ctl_reg: decoder bits out of range");
   end

   logic [N-1:0] chain_q;
   logic         xfer_ok;

   assign ld_clash = shift_ld & xfer_ld;
   assign xfer_ok  = xfer_ld & ~shift_ld;

   shift_chain #(.N(N)) u_chain (
      .rst_n    (rst_n),
      .ser_din  (ser_din),
      .shift_ld (shift_ld),
      .chain_q  (chain_q)
   );

   hold_reg #(.N(N)) u_hold (
      .rst_n   (rst_n),
      .xfer_ok (xfer_ok),
      .chain_q (chain_q),
      .state_q (state_q)
   );

   dec_2to4 #(.ENABLE(DEC_EN)) u_dec (
      .sel (state_q[DEC_MSB:DEC_LSB]),
      .y   (dec_out)
   );

   always @(state_q) begin
      if (rst_n) begin
         // R4 R6
         xfer_only_chk: assert (xfer_ld && !shift_ld)
            else $error("outputs moved outside a clean transfer");
      end
   end
endmodule

// File: tb/latch_ctl_reg_test.sv
module latch_ctl_reg_test;
   localparam int NA = 12;
   localparam int DLA = 5;
   localparam int NB = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, ser_din, shift_ld, xfer_ld;
   logic [NA-1:0] st_a;
   logic [NB-1:0] st_b;
   logic [3:0] dec_a, dec_b;
   logic clash_a, clash_b;

   latch_ctl_reg #(.N(NA), .DEC_EN(1'b1), .DEC_LSB(DLA)) uut (
      .rst_n(rst_n), .ser_din(ser_din), .shift_ld(shift_ld), .xfer_ld(xfer_ld),
      .state_q(st_a), .dec_out(dec_a), .ld_clash(clash_a));

   latch_ctl_reg #(.N(NB), .DEC_EN(1'b0), .DEC_LSB(0)) uut_b (
      .rst_n(rst_n), .ser_din(ser_din), .shift_ld(shift_ld), .xfer_ld(xfer_ld),
      .state_q(st_b), .dec_out(dec_b), .ld_clash(clash_b));

   int total = 0;
   int bad = 0;
   bit finished = 0;

   typedef struct {
      string       tag;
      logic [31:0] st;
      logic [3:0]  dc;
      logic [31:0] stb;
   } exp_t;
   exp_t sb[$];
   event chk_ev;

   logic [NA-1:0] mod_a, held_a;
   logic [NB-1:0] mod_b, held_b;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] dec_of(input logic [NA-1:0] s);
      return 4'b0001 << s[DLA+1 -: 2];
   endfunction

   // monitor: pops expected items and compares
   initial begin
      exp_t it;
      forever begin
         @(chk_ev);
         while (sb.size() > 0) begin
            it = sb.pop_front();
            check({it.tag, " state"}, 32'(st_a), it.st);
            check({it.tag, " R7 dec"}, 32'(dec_a), 32'(it.dc));
            check({it.tag, " narrow"}, 32'(st_b), it.stb);
            check({it.tag, " R7 dec off"}, 32'(dec_b), 32'd0);
         end
      end
   end

   task automatic expect_held(input string tag);
      exp_t it;
      it.tag = tag; it.st = 32'(held_a); it.dc = dec_of(held_a); it.stb = 32'(held_b);
      sb.push_back(it);
      -> chk_ev;
      #1;
   endtask

   task automatic shift_bit(input logic b);
      ser_din = b;
      shift_ld = 1'b1;
      @(negedge clk);
      shift_ld = 1'b0;
      mod_a = {mod_a[NA-2:0], b};
      mod_b = {mod_b[NB-2:0], b};
      @(negedge clk);
   endtask

   task automatic shift_word(input logic [NA-1:0] w);
      for (int i = NA-1; i >= 0; i--) begin
         shift_bit(w[i]);
         if (i == NA/2) expect_held("R4 mid-shift");
      end
      expect_held("R4 after shift");
   endtask

   task automatic xfer(input string tag);
      xfer_ld = 1'b1;
      @(negedge clk); @(negedge clk);
      xfer_ld = 1'b0;
      @(negedge clk);
      held_a = mod_a; held_b = mod_b;
      expect_held(tag);
   endtask

   initial begin
      rst_n = 1'b0; ser_din = 1'b0; shift_ld = 1'b0; xfer_ld = 1'b0;
      mod_a = '0; mod_b = '0; held_a = '0; held_b = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 state", 32'(st_a), 32'd0);
      check("R1 dec", 32'(dec_a), 32'd1);
      check("R1 clash", 32'(clash_a), 32'd0);
      check("R1 dec off", 32'(dec_b), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 random words
      for (int k = 0; k < 6; k++) begin
         logic [NA-1:0] w;
         w = NA'($urandom);
         shift_word(w);
         xfer("R3 random");
         check("R3 word", 32'(st_a), 32'(w));
      end

      // R7 all four decoder codes
      for (int c = 0; c < 4; c++) begin
         logic [NA-1:0] w;
         w = NA'($urandom);
         w[DLA+1 -: 2] = 2'(c);
         shift_word(w);
         xfer("R7 code");
         check("R7 dec code", 32'(dec_a), 32'(4'b0001 << c));
      end

      // R2 narrow chain drops its top bit: shift 1,0,1 into 2-bit chain
      shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
      xfer("R2 shift order");
      check("R2 narrow drop", 32'(st_b), 32'b01);

      // R8 ser_din toggles while shift_ld high; last value wins
      ser_din = 1'b0;
      shift_ld = 1'b1;
      @(negedge clk); ser_din = 1'b1;
      @(negedge clk); ser_din = 1'b0;
      @(negedge clk); ser_din = 1'b1;
      @(negedge clk);
      shift_ld = 1'b0;
      mod_a = {mod_a[NA-2:0], 1'b1};
      mod_b = {mod_b[NB-2:0], 1'b1};
      @(negedge clk);
      xfer("R8 last value");
      check("R8 bit0", 32'(st_a[0]), 32'd1);

      // R5 hold with loads low while ser_din wiggles
      repeat (100) begin
         ser_din = ~ser_din;
         @(negedge clk);
      end
      expect_held("R5 hold");

      // R6 both loads high: clash flag, transfer ignored
      shift_word(~held_a);
      shift_ld = 1'b1; ser_din = 1'b0;
      @(negedge clk);
      xfer_ld = 1'b1;
      @(negedge clk);
      check("R6 clash", 32'(clash_a), 32'd1);
      check("R6 clash narrow", 32'(clash_b), 32'd1);
      expect_held("R6 ignored");
      xfer_ld = 1'b0;
      @(negedge clk);
      check("R6 clash clear", 32'(clash_a), 32'd0);
      shift_ld = 1'b0;
      mod_a = {mod_a[NA-2:0], 1'b0};
      mod_b = {mod_b[NB-2:0], 1'b0};
      @(negedge clk);
      expect_held("R6 after");

      // R5 transparency: xfer high follows chain across later shift? no - follow while high
      xfer("R5 transfer");

      // R1 reset after load
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rearm state", 32'(st_a), 32'd0);
      check("R1 rearm dec", 32'(dec_a), 32'd1);
      rst_n = 1'b1;
      mod_a = '0; mod_b = '0; held_a = '0; held_b = '0;
      @(negedge clk);
      xfer("R1 cleared chain");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule